// File: doc/BRIEF.md
# Dual-Rail Four-Phase Register Stage

This block is one register stage of a delay-insensitive pipeline. Each logical bit of a word travels on a pair of wires, a true rail and a false rail. A stage captures an incoming token in per-rail state-holding elements that only fill while the following stage is ready for new data, and only empty once the following stage has taken the previous token. A completion detector watches the held word and reports either that the whole word is valid or that the whole word has returned to the empty state. The acknowledge sent back to the previous stage is derived from that detector.

Stages of this kind are chained with arbitrary logic between them. Transfers follow a four-phase return-to-zero protocol. The sender puts a token onto an empty bus. The stage captures it and raises `ack_to_prev`. The sender then empties the bus. The stage empties once `ack_from_next` shows the next stage holds the token, and then lowers `ack_to_prev`. There is no valid/ready pair here: back-pressure is expressed entirely by `ack_from_next`. While `ack_from_next` is high, no rail of the stage can rise, so a new token waits on the input wires. While it is low, no held rail can fall, so the current token is kept even if the input bus is already empty.

The state-holding elements are modelled as registers that update on the rising edge of `clk`. Every transition therefore appears at the outputs one edge after the inputs that cause it.

Top module: `dr_stage`

## Requirements
- R1: Bit i of a word is carried as the pair (`*_t[i]`, `*_f[i]`). The pair (1,0) is logic 1, (0,1) is logic 0, and (0,0) is the empty spacer. On output, a valid word satisfies `out_t` equal to the word and `out_f` equal to its inverse.
- R2: When every input pair is legal, no output pair is ever (1,1).
- R3: While `rst_n` is low, and on the first cycle after reset, all output rails are 0, `ack_to_prev` is 0, `done_spacer` is 1 and `done_valid` is 0.
- R4: A held rail rises on the rising clock edge at which its input rail is 1 and `ack_from_next` is 0. No held rail rises at an edge where `ack_from_next` is 1.
- R5: A held rail falls on the rising clock edge at which its input rail is 0 and `ack_from_next` is 1. No held rail falls at an edge where `ack_from_next` is 0.
- R6: `done_valid` is 1 exactly when every held pair has one rail high. `done_spacer` is 1 exactly when every held rail is 0. A partly filled word gives neither, and the two are never 1 together.
- R7: `ack_to_prev` rises one edge after the held word becomes fully valid, and stays low while the word is only partly filled.
- R8: `ack_to_prev` falls one edge after the held word becomes all spacer, and stays high while any held pair is still non-empty.
- R9: The word presented at the outputs after a transfer equals the word applied at the inputs, for all data patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock for the state-holding elements |
| rst_n | input | 1 | Active-low reset; empties the stage |
| in_t | input | W | True rails of the incoming word |
| in_f | input | W | False rails of the incoming word |
| ack_from_next | input | 1 | Acknowledge from the following stage; high means it holds the token |
| out_t | output | W | True rails of the held word |
| out_f | output | W | False rails of the held word |
| ack_to_prev | output | 1 | Acknowledge to the preceding stage |
| done_valid | output | 1 | Every held bit carries data |
| done_spacer | output | 1 | Every held rail is low |

## Verification
The hardest situations to reach from the ports are those where the stage must hold state against its inputs. One is a partly arrived word, which must leave both completion flags and the acknowledge unchanged. The others are a new token, or an emptied input bus, that arrives while the following stage has not yet moved through its half of the handshake. The bench reaches them by splitting some words so that half of the bits arrive one cycle ahead of the rest. On chosen tokens it also raises `ack_from_next` before the data arrives, and it always empties the input bus a cycle before the next stage acknowledges. Random words, with all-zero, all-one and alternating words mixed in, are checked against values the bench derives from each word.

// File: rtl/dr_pipe_pkg.sv
package dr_pipe_pkg;

  // Code carried by one rail pair, written as {true, false}
  typedef enum logic [1:0] {
    DR_SPACER = 2'b00,
    DR_ZERO   = 2'b01,
    DR_ONE    = 2'b10,
    DR_BAD    = 2'b11
  } dr_code_e;

  function automatic dr_code_e dr_classify(input logic t, input logic f);
    return dr_code_e'({t, f});
  endfunction

  function automatic logic dr_is_data(input dr_code_e c);
    return (c == DR_ZERO) || (c == DR_ONE);
  endfunction

endpackage

// File: rtl/dr_celem.sv
// N-input Muller C-element modelled as a register: it sets when every
// input is high, clears when every input is low, and holds otherwise.
module dr_celem #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_v,
  output logic         q
);
  logic all_hi;
  logic all_lo;

  assign all_hi = &in_v;
  assign all_lo = ~|in_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (all_hi) q <= 1'b1;
    else if (all_lo) q <= 1'b0;
  end
endmodule

// File: rtl/dr_bit_cell.sv
// One dual-rail bit: each rail is gated by the inverted downstream acknowledge.
module dr_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_t_in,
  input  logic rail_f_in,
  input  logic ack_next,
  output logic rail_t_q,
  output logic rail_f_q
);
  logic ready_n;

  assign ready_n = ~ack_next;

  dr_celem #(.N(2)) cel_t_i (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  ({rail_t_in, ready_n}),
    .q     (rail_t_q)
  );

  dr_celem #(.N(2)) cel_f_i (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  ({rail_f_in, ready_n}),
    .q     (rail_f_q)
  );
endmodule

// File: rtl/dr_completion.sv
// Completion detector over the held word plus the acknowledge C-element.
module dr_completion
  import dr_pipe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] held_t,
  input  logic [W-1:0] held_f,
  output logic         all_valid,
  output logic         all_empty,
  output logic         ack_q
);
  logic [W-1:0] bit_data;
  logic [W-1:0] bit_busy;

  for (genvar i = 0; i < W; i++) begin : g_bit
    dr_code_e code;
    assign code        = dr_classify(held_t[i], held_f[i]);
    assign bit_data[i] = dr_is_data(code);
    assign bit_busy[i] = (code != DR_SPACER);
  end

  assign all_valid = &bit_data;
  assign all_empty = ~|bit_busy;

  dr_celem #(.N(W)) ack_cel_i (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (bit_busy),
    .q     (ack_q)
  );
endmodule

// File: rtl/dr_stage.sv
// Dual-rail four-phase register stage.
module dr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  input  logic         ack_from_next,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  output logic         ack_to_prev,
  output logic         done_valid,
  output logic         done_spacer
);
  logic [W-1:0] held_t;
  logic [W-1:0] held_f;

  for (genvar i = 0; i < W; i++) begin : g_cell
    dr_bit_cell cell_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rail_t_in (in_t[i]),
      .rail_f_in (in_f[i]),
      .ack_next  (ack_from_next),
      .rail_t_q  (held_t[i]),
      .rail_f_q  (held_f[i])
    );
  end

  dr_completion #(.W(W)) cd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .held_t    (held_t),
    .held_f    (held_f),
    .all_valid (done_valid),
    .all_empty (done_spacer),
    .ack_q     (ack_to_prev)
  );

  assign out_t = held_t;
  assign out_f = held_f;
endmodule

// File: rtl/dr_stage_chk.sv
module dr_stage_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack_from_next,
  input logic [W-1:0] out_t,
  input logic [W-1:0] out_f,
  input logic         ack_to_prev,
  input logic         done_valid,
  input logic         done_spacer
);
  // R2: no output pair reaches the illegal code
  a_r2_no_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (out_t & out_f) == '0);

  // R4: rails cannot rise while the next stage still holds a token
  a_r4_no_rise_when_acked: assert property (@(posedge clk) disable iff (!rst_n)
    ack_from_next |=> (((out_t & ~$past(out_t)) | (out_f & ~$past(out_f))) == '0));

  // R5: rails cannot fall before the next stage acknowledges
  a_r5_no_fall_unacked: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_from_next |=> (((~out_t & $past(out_t)) | (~out_f & $past(out_f))) == '0));

  // R6: the two completion flags are exclusive
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_valid, done_spacer}));

  // R7: acknowledge rises only after a fully valid word
  a_r7_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_to_prev) |-> $past(done_valid));

  // R8: acknowledge falls only after an empty word
  a_r8_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_to_prev) |-> $past(done_spacer));
endmodule

bind dr_stage dr_stage_chk #(.W(W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ack_from_next (ack_from_next),
  .out_t         (out_t),
  .out_f         (out_f),
  .ack_to_prev   (ack_to_prev),
  .done_valid    (done_valid),
  .done_spacer   (done_spacer)
);

// File: tb/dr_stage_tb_top.sv
`timescale 1ns/1ps
module dr_stage_tb_top;
  localparam int W      = 8;
  localparam int TOKENS = 60;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] in_t = '0;
  logic [W-1:0] in_f = '0;
  logic         ack_from_next = 1'b0;
  logic [W-1:0] out_t, out_f;
  logic         ack_to_prev, done_valid, done_spacer;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dr_stage #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f),
    .ack_from_next(ack_from_next), .out_t(out_t), .out_f(out_f),
    .ack_to_prev(ack_to_prev), .done_valid(done_valid), .done_spacer(done_spacer)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // encodings from R1: true rail = bit, false rail = inverse, masked bits are spacer
  function automatic logic [W-1:0] enc_t(input logic [W-1:0] w, input logic [W-1:0] m);
    return w & m;
  endfunction
  function automatic logic [W-1:0] enc_f(input logic [W-1:0] w, input logic [W-1:0] m);
    return ~w & m;
  endfunction

  // R2 monitor: illegal pair check every cycle
  always @(negedge clk) begin
    if (rst_n && !finished)
      check((out_t & out_f) == '0, "R2 no (1,1) pair", 64'(out_t & out_f), 64'd0);
  end

  task automatic transfer(input logic [W-1:0] w, input bit stagger, input bit block);
    logic [W-1:0] lo_mask;
    lo_mask = {W{1'b0}};
    for (int i = 0; i < W/2; i++) lo_mask[i] = 1'b1;

    if (block) begin
      ack_from_next = 1'b1;
      in_t = enc_t(w, '1); in_f = enc_f(w, '1);
      step();
      check(out_t == '0 && out_f == '0, "R4 blocked while acked", 64'({out_t, out_f}), 64'd0);
      ack_from_next = 1'b0;
    end

    if (stagger) begin
      in_t = enc_t(w, lo_mask); in_f = enc_f(w, lo_mask);
      step();
      check(!done_valid && !done_spacer, "R6 partial word flags",
            64'({done_valid, done_spacer}), 64'd0);
      check(ack_to_prev == 1'b0, "R7 no ack on partial word", 64'(ack_to_prev), 64'd0);
    end

    in_t = enc_t(w, '1); in_f = enc_f(w, '1);
    step();
    check(out_t == w, "R9 word delivered", 64'(out_t), 64'(w));
    check(out_f == ~w, "R1 false rails", 64'(out_f), 64'(~w));
    check(done_valid && !done_spacer, "R6 done_valid on full word",
          64'({done_valid, done_spacer}), 64'b10);
    check(ack_to_prev == 1'b0, "R7 ack one edge later", 64'(ack_to_prev), 64'd0);
    step();
    check(ack_to_prev == 1'b1, "R7 ack raised", 64'(ack_to_prev), 64'd1);

    in_t = '0; in_f = '0;
    step();
    check(out_t == w && out_f == ~w, "R5 hold without downstream ack",
          64'({out_t, out_f}), 64'({w, ~w}));
    check(ack_to_prev == 1'b1, "R8 ack held while word present", 64'(ack_to_prev), 64'd1);

    ack_from_next = 1'b1;
    step();
    check(out_t == '0 && out_f == '0, "R5 release on downstream ack",
          64'({out_t, out_f}), 64'd0);
    check(done_spacer && !done_valid, "R6 done_spacer", 64'({done_valid, done_spacer}), 64'b01);
    check(ack_to_prev == 1'b1, "R8 ack one edge later", 64'(ack_to_prev), 64'd1);
    step();
    check(ack_to_prev == 1'b0, "R8 ack lowered", 64'(ack_to_prev), 64'd0);
    ack_from_next = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    check(out_t == '0 && out_f == '0 && !ack_to_prev, "R3 reset outputs",
          64'({out_t, out_f, ack_to_prev}), 64'd0);
    check(done_spacer && !done_valid, "R3 reset flags", 64'({done_valid, done_spacer}), 64'b01);
    rst_n = 1'b1;
    step();
    check(out_t == '0 && out_f == '0 && !ack_to_prev && done_spacer, "R3 after reset",
          64'({out_t, out_f, ack_to_prev, done_spacer}), 64'd1);

    transfer('0, 1'b0, 1'b0);
    transfer('1, 1'b1, 1'b0);
    transfer({W/2{2'b10}}, 1'b1, 1'b1);
    transfer({W/2{2'b01}}, 1'b0, 1'b1);
    for (int k = 0; k < TOKENS; k++) begin
      logic [W-1:0] w;
      w = W'($urandom);
      transfer(w, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule